// File: doc/BRIEF.md
# Packet Statistics Clock-Crossing and LED Display

This block sits behind a receive-side header parser. The parser runs on the slow receive clock. The block moves the parser's per-packet results into the fast system clock domain and keeps a frame counter and a counter of IP packets that passed their checksum. It also drives a four-bit LED display and a red error indicator.

In the receive domain the block registers every single-bit event and flag. It also keeps a holding register for the 8-bit protocol field, which loads only while the IP-valid strobe is high. The flags then cross through two-flop synchronizers. The held protocol crosses through a two-stage register chain; this is safe because the held value changes only when a new packet arrives.

In the system domain the block counts only the rising edge of each synchronized event. A debounced push button steps a 2-bit display mode. Each mode routes a different nibble to the LEDs.

The parser outputs are pulses that cannot be stalled. There is therefore no valid/ready handshake and no back-pressure at this block's edge. Every input sits on a plain pin. Each event must stay high for at least one receive clock, and successive events must be separated by at least one low receive cycle. The checksum-ok flag must be presented in the same receive cycle as the IP-valid strobe.

Top module: `pkt_stat_cdc`

## Requirements
- R1: After system reset, both counters, the display mode, the LED output, the held protocol output and the red indicator all read zero.
- R2: A frame-done or IP-valid event that stays high for several receive cycles is counted exactly once.
- R3: Each frame-done event increments the frame counter by one. After ten frames from reset, display mode 0 shows 0xA.
- R4: The IP counter increments on an IP-valid event only when checksum-ok is high in that same receive cycle. Otherwise the IP counter holds.
- R5: The protocol output, and the mode-2 LED nibble, take the protocol value present during the last IP-valid event. Protocol changes while IP-valid is low have no effect.
- R6: Each debounced button press advances the display mode by one, modulo 4 (3 wraps to 0).
- R7: The LEDs show, by mode:
  - mode 0 (value 0): frame count bits [3:0]
  - mode 1 (value 1): the external nibble input
  - mode 2 (value 2): protocol bits [3:0]
  - mode 3 (value 3): frame count bits [3:0] again
- R8: A button level that lasts fewer than DEB_CYCLES consecutive system cycles after synchronization does not change the mode.
- R9: The red indicator is the OR of two separate nets:
  - the synchronized receiver-error level
  - a sticky statistics error, set by any of the version, header-length or checksum error flags and cleared only by system reset
- R10: Both counters wrap modulo 2^CNT_W.
- R11: A frame-done and an IP-valid event in the same receive cycle increment both counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rx_clk | input | 1 | Receive-domain clock |
| rx_rst_n | input | 1 | Receive-domain reset, active low |
| frame_done_i | input | 1 | Frame accepted event from the parser |
| ip_valid_i | input | 1 | IP header parsed event |
| ip_proto_i | input | 8 | Protocol field, meaningful while ip_valid_i is high |
| ip_csum_ok_i | input | 1 | Header checksum correct, presented with ip_valid_i |
| ip_ver_err_i | input | 1 | Version field error flag |
| ip_ihl_err_i | input | 1 | Header-length field error flag |
| ip_csum_err_i | input | 1 | Checksum error flag |
| rx_err_i | input | 1 | Receiver error level |
| sys_clk | input | 1 | System-domain clock |
| sys_rst_n | input | 1 | System-domain reset, active low |
| mode_btn_i | input | 1 | Raw display-mode button |
| ext_nib_i | input | 4 | Low nibble of an external register, shown in mode 1 |
| led_o | output | 4 | LED nibble |
| err_red_o | output | 1 | Red error indicator |
| frame_cnt_o | output | CNT_W | Frame counter |
| ip_cnt_o | output | CNT_W | Checksum-good IP packet counter |
| ip_proto_o | output | 8 | Protocol value carried into the system domain |
| disp_mode_o | output | 2 | Current display mode |

## Verification
Two pairs of functions can land in the same cycle, and the bench covers both:
- **Both counters at once.** A frame-done and an IP-valid event arriving in one receive cycle both reach their counters on the same system edge. The protocol sweep provokes this on every packet, and the bench checks that both counters advanced by their arithmetically expected amounts, with the IP counter skipping packets that lacked checksum-ok.
- **Error sources together.** The receiver-error level and the sticky statistics error can both be high at once. The bench provokes this by holding receiver error while pulsing a header error, then judges that the indicator stays lit after the level drops and clears only on reset.

// File: rtl/pstat_pkg.sv
package pstat_pkg;
  typedef enum logic [1:0] {
    DM_FRAMES = 2'd0,
    DM_EXT    = 2'd1,
    DM_PROTO  = 2'd2,
    DM_ALT    = 2'd3
  } disp_mode_e;

  localparam int unsigned N_FLAGS = 7;
  localparam int unsigned F_FRAME = 6;
  localparam int unsigned F_VALID = 5;
  localparam int unsigned F_OK    = 4;
  localparam int unsigned F_VER   = 3;
  localparam int unsigned F_IHL   = 2;
  localparam int unsigned F_CERR  = 1;
  localparam int unsigned F_RXERR = 0;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/rise_det.sv
module rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic pulse
);
  logic d_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= d;
  end
  assign pulse = d & ~d_q;
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned DEB_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  output logic press
);
  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(DEB_CYCLES - 1);

  logic          btn_s;
  logic          lvl_q;
  logic          press_q;
  logic [CW-1:0] cnt_q;

  bit_sync #(.W(1)) u_sync (.clk(clk), .rst_n(rst_n), .d(btn_raw), .q(btn_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
      press_q <= 1'b0;
    end else begin
      press_q <= 1'b0;
      if (btn_s == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LIM) begin
        lvl_q   <= btn_s;
        cnt_q   <= '0;
        press_q <= btn_s;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
  assign press = press_q;
endmodule

// File: rtl/pkt_counters.sv
module pkt_counters #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_ev,
  input  logic             ip_ev,
  input  logic             csum_ok,
  output logic [CNT_W-1:0] frame_cnt,
  output logic [CNT_W-1:0] ip_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_cnt <= '0;
      ip_cnt    <= '0;
    end else begin
      if (frame_ev)           frame_cnt <= frame_cnt + 1'b1;
      if (ip_ev && csum_ok)   ip_cnt    <= ip_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pkt_stat_cdc.sv
module pkt_stat_cdc
  import pstat_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DEB_CYCLES = 2_000_000
) (
  input  logic             rx_clk,
  input  logic             rx_rst_n,
  input  logic             frame_done_i,
  input  logic             ip_valid_i,
  input  logic [7:0]       ip_proto_i,
  input  logic             ip_csum_ok_i,
  input  logic             ip_ver_err_i,
  input  logic             ip_ihl_err_i,
  input  logic             ip_csum_err_i,
  input  logic             rx_err_i,
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             mode_btn_i,
  input  logic [3:0]       ext_nib_i,
  output logic [3:0]       led_o,
  output logic             err_red_o,
  output logic [CNT_W-1:0] frame_cnt_o,
  output logic [CNT_W-1:0] ip_cnt_o,
  output logic [7:0]       ip_proto_o,
  output logic [1:0]       disp_mode_o
);
  // receive domain: register flags, hold protocol while valid
  logic [N_FLAGS-1:0] rx_flags_q;
  logic [7:0]         proto_hold_q;

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      rx_flags_q   <= '0;
      proto_hold_q <= '0;
    end else begin
      rx_flags_q[F_FRAME] <= frame_done_i;
      rx_flags_q[F_VALID] <= ip_valid_i;
      rx_flags_q[F_OK]    <= ip_csum_ok_i;
      rx_flags_q[F_VER]   <= ip_ver_err_i;
      rx_flags_q[F_IHL]   <= ip_ihl_err_i;
      rx_flags_q[F_CERR]  <= ip_csum_err_i;
      rx_flags_q[F_RXERR] <= rx_err_i;
      if (ip_valid_i) proto_hold_q <= ip_proto_i;
    end
  end

  // system domain
  logic [N_FLAGS-1:0] sys_flags;
  logic [7:0]         proto_s;
  logic               frame_ev, ip_ev, press;
  logic               rx_err_s;
  logic               stats_err_q;
  disp_mode_e         mode_q;
  logic [3:0]         led_q;

  bit_sync #(.W(N_FLAGS)) u_flag_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(rx_flags_q), .q(sys_flags));

  bit_sync #(.W(8)) u_proto_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(proto_hold_q), .q(proto_s));

  rise_det u_frame_edge (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(sys_flags[F_FRAME]), .pulse(frame_ev));

  rise_det u_valid_edge (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(sys_flags[F_VALID]), .pulse(ip_ev));

  pkt_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(sys_clk), .rst_n(sys_rst_n),
    .frame_ev(frame_ev), .ip_ev(ip_ev), .csum_ok(sys_flags[F_OK]),
    .frame_cnt(frame_cnt_o), .ip_cnt(ip_cnt_o));

  btn_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk(sys_clk), .rst_n(sys_rst_n), .btn_raw(mode_btn_i), .press(press));

  assign rx_err_s = sys_flags[F_RXERR];

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      stats_err_q <= 1'b0;
      mode_q      <= DM_FRAMES;
      led_q       <= '0;
    end else begin
      if (sys_flags[F_VER] || sys_flags[F_IHL] || sys_flags[F_CERR])
        stats_err_q <= 1'b1;
      if (press) mode_q <= disp_mode_e'(mode_q + 2'd1);
      case (mode_q)
        DM_EXT:   led_q <= ext_nib_i;
        DM_PROTO: led_q <= proto_s[3:0];
        default:  led_q <= frame_cnt_o[3:0];
      endcase
    end
  end

  assign err_red_o   = rx_err_s | stats_err_q;
  assign led_o       = led_q;
  assign ip_proto_o  = proto_s;
  assign disp_mode_o = mode_q;
endmodule

// File: rtl/pkt_stat_cdc_chk.sv
module pkt_stat_cdc_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] frame_cnt,
  input logic [CNT_W-1:0] ip_cnt,
  input logic [1:0]       mode,
  input logic [3:0]       led,
  input logic [3:0]       ext_nib,
  input logic             red,
  input logic             rx_err_s,
  input logic             stats_err
);
  p_frame_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (frame_cnt == $past(frame_cnt) || frame_cnt == CNT_W'($past(frame_cnt) + 1'b1)));

  p_ip_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ip_cnt == $past(ip_cnt) || ip_cnt == CNT_W'($past(ip_cnt) + 1'b1)));

  p_mode_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mode == $past(mode) || mode == 2'($past(mode) + 2'd1)));

  p_led_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |=> (led == $past(ext_nib)));

  p_red_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_s |-> red);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stats_err |=> (stats_err && red));
endmodule

bind pkt_stat_cdc pkt_stat_cdc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(sys_clk), .rst_n(sys_rst_n),
  .frame_cnt(frame_cnt_o), .ip_cnt(ip_cnt_o),
  .mode(disp_mode_o), .led(led_o), .ext_nib(ext_nib_i),
  .red(err_red_o), .rx_err_s(rx_err_s), .stats_err(stats_err_q));

// File: tb/sim_pkt_stat_cdc.sv
module sim_pkt_stat_cdc;
  localparam int CW  = 8;
  localparam int DEB = 4;

  logic sys_clk = 0, rx_clk = 0;
  logic sys_rst_n = 0, rx_rst_n = 0;
  logic frame_done = 0, ip_valid = 0, csum_ok = 0;
  logic ver_err = 0, ihl_err = 0, cerr = 0, rx_err = 0;
  logic [7:0] proto = 0;
  logic mode_btn = 0;
  logic [3:0] ext_nib = 4'h9;
  logic [3:0] led;
  logic red;
  logic [CW-1:0] frame_cnt, ip_cnt;
  logic [7:0] proto_o;
  logic [1:0] mode_o;

  always #4  sys_clk = ~sys_clk;
  always #20 rx_clk  = ~rx_clk;

  pkt_stat_cdc #(.CNT_W(CW), .DEB_CYCLES(DEB)) u0 (
    .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .frame_done_i(frame_done),
    .ip_valid_i(ip_valid), .ip_proto_i(proto), .ip_csum_ok_i(csum_ok),
    .ip_ver_err_i(ver_err), .ip_ihl_err_i(ihl_err), .ip_csum_err_i(cerr),
    .rx_err_i(rx_err), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .mode_btn_i(mode_btn), .ext_nib_i(ext_nib), .led_o(led),
    .err_red_o(red), .frame_cnt_o(frame_cnt), .ip_cnt_o(ip_cnt),
    .ip_proto_o(proto_o), .disp_mode_o(mode_o));

  int total = 0, fails = 0;
  bit done = 0;
  int m_frames = 0, m_ips = 0, m_mode = 0, m_proto = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_led();
    case (m_mode)
      1: return int'(ext_nib);
      2: return m_proto % 16;
      default: return m_frames % 16;
    endcase
  endfunction

  task automatic do_reset();
    sys_rst_n = 0; rx_rst_n = 0;
    repeat (3) @(negedge rx_clk);
    sys_rst_n = 1; rx_rst_n = 1;
    repeat (2) @(negedge rx_clk);
    @(negedge sys_clk);
    m_frames = 0; m_ips = 0; m_mode = 0; m_proto = 0;
  endtask

  task automatic pkt(input logic fd, input logic iv, input int pr, input logic ok, input int hold);
    @(negedge rx_clk);
    frame_done = fd; ip_valid = iv; proto = 8'(pr); csum_ok = ok;
    repeat (hold) @(negedge rx_clk);
    frame_done = 0; ip_valid = 0; csum_ok = 0;
    repeat (4) @(negedge rx_clk);
    @(negedge sys_clk);
    if (fd) m_frames++;
    if (iv) begin m_proto = pr; if (ok) m_ips++; end
  endtask

  task automatic press();
    mode_btn = 1; repeat (20) @(negedge sys_clk);
    mode_btn = 0; repeat (20) @(negedge sys_clk);
    m_mode = (m_mode + 1) % 4;
  endtask

  task automatic settle();
    repeat (6) @(negedge rx_clk);
    @(negedge sys_clk);
  endtask

  initial begin
    repeat (200000) @(posedge sys_clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 frame_cnt", int'(frame_cnt), 0);
    chk("R1 ip_cnt", int'(ip_cnt), 0);
    chk("R1 mode", int'(mode_o), 0);
    chk("R1 led", int'(led), 0);
    chk("R1 red", int'(red), 0);
    chk("R1 proto", int'(proto_o), 0);

    // R3 burst of ten shows 0xA in mode 0
    for (int i = 0; i < 10; i++) pkt(1, 1, 17, 1, 1);
    chk("R3 burst led", int'(led), 10);
    chk("R3 burst frames", int'(frame_cnt), 10);
    chk("R4 burst ips", int'(ip_cnt), 10);

    // R6/R7 mode 1 then 2
    press();
    chk("R6 mode1", int'(mode_o), 1);
    chk("R7 ext led", int'(led), exp_led());
    press();
    chk("R6 mode2", int'(mode_o), 2);

    // sweep all protocols, simultaneous frame+valid (R11), some without ok (R4)
    for (int p = 0; p < 256; p++) begin
      pkt(1, 1, p, (p % 3) != 0, 1);
      chk("R11 frames", int'(frame_cnt), m_frames % 256);
      chk("R4 ips", int'(ip_cnt), m_ips % 256);
      chk("R5 proto", int'(proto_o), p);
      chk("R7 proto led", int'(led), exp_led());
    end
    // R10 wrap: 266 frames modulo 256
    chk("R10 frame wrap", int'(frame_cnt), 266 % 256);

    // R5 protocol change without valid ignored
    pkt(1, 0, 8'h3C, 0, 1);
    chk("R5 proto hold", int'(proto_o), 255);
    chk("R5 led hold", int'(led), 15);

    // R2 long events counted once
    pkt(1, 0, 0, 0, 3);
    chk("R2 long frame", int'(frame_cnt), m_frames % 256);
    pkt(0, 1, 8'h06, 1, 3);
    chk("R2 long valid", int'(ip_cnt), m_ips % 256);
    chk("R5 tcp led", int'(led), 6);

    // R8 glitch ignored
    mode_btn = 1; repeat (2) @(negedge sys_clk);
    mode_btn = 0; repeat (20) @(negedge sys_clk);
    chk("R8 glitch mode", int'(mode_o), 2);

    // R6 wrap, R7 mode 3 and 0
    press();
    chk("R6 mode3", int'(mode_o), 3);
    chk("R7 mode3 led", int'(led), exp_led());
    press();
    chk("R6 wrap", int'(mode_o), 0);
    chk("R7 mode0 led", int'(led), exp_led());

    // R9 error indicator
    chk("R9 idle", int'(red), 0);
    @(negedge rx_clk); rx_err = 1; settle();
    chk("R9 rx level", int'(red), 1);
    @(negedge rx_clk); ver_err = 1; @(negedge rx_clk); ver_err = 0;
    rx_err = 0; settle();
    chk("R9 sticky ver", int'(red), 1);
    do_reset();
    chk("R9 reset clears", int'(red), 0);
    @(negedge rx_clk); ihl_err = 1; @(negedge rx_clk); ihl_err = 0; settle();
    chk("R9 ihl", int'(red), 1);
    do_reset();
    @(negedge rx_clk); cerr = 1; @(negedge rx_clk); cerr = 0; settle();
    chk("R9 csum err", int'(red), 1);
    do_reset();
    @(negedge rx_clk); rx_err = 1; settle(); rx_err = 0; settle();
    chk("R9 rx not sticky", int'(red), 0);

    // R4 no ok means no IP count
    pkt(1, 1, 1, 0, 1);
    chk("R4 no ok", int'(ip_cnt), 0);
    chk("R3 frame", int'(frame_cnt), 1);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule